// File: doc/BRIEF.md
# Four-level page table walker

The block turns a 64-bit virtual address into a physical address by fetching up to four 64-bit table entries from memory. It works through the levels one at a time. Each level's entry supplies the frame of the next table, and the block issues exactly one memory read per level through a request/response memory port. A translation request carries the virtual address, the frame of the root table and three access attributes: write, user mode and instruction fetch. The response carries the physical address, the level at which the walk ended, the merged permission bits and a fault code.

The walk ends early when an entry at the second or third level read has its large-page bit set. The result is then a 1 GiB or a 2 MiB page. An address whose upper bits are not a sign extension of bit 47 is refused before any memory traffic. A missing entry stops the walk with a not-present fault. An access that the merged permissions deny returns a protection fault. The block handles one translation at a time and waits any number of cycles for the memory port.

Top module: `ptw4_walker`

## Requirements
- R1: When bits 63:48 of the virtual address are not all equal to bit 47, the response has fault code 1. No memory read is made, and the physical address, level and permission outputs are 0.
- R2: Reads go from the root downward, using address bits 47:39, 38:30, 29:21 and then 20:12 as the index. Each read address is the current table frame (the root frame, or bits 51:12 of the previous entry) followed by the 9-bit index and three zero bits.
- R3: When bit 0 of a fetched entry is clear, the walk stops after that read with fault code 2, and the physical address, level and permission outputs are 0.
- R4: When bit 7 is set in the entry from the second read, the walk ends after two reads. The response is level code 2 and physical address {entry[51:30], va[29:0]}.
- R5: When bit 7 is set in the entry from the third read, the walk ends after three reads. The response is level code 1 and physical address {entry[51:21], va[20:0]}. Entry bits 20:12 are not used.
- R6: Otherwise the walk makes four reads and responds with level code 0 and physical address {entry[51:12], va[11:0]}. Bit 7 in the first or fourth entry does not end or change the walk, and entry bits 11:9 never affect the result.
- R7: The write and user permissions reported are the AND of entry bits 1 and 2 over all entries visited. No-execute is the OR of entry bit 63 over all entries visited. These are reported with fault codes 0 and 3.
- R8: Fault code 3, with physical address 0, is returned in three cases: a write request where the merged write permission is clear, a user request where the merged user permission is clear, or a fetch request where merged no-execute is set. Fault code 0 means success.
- R9: A request is taken only while req_ready is high, and at most one translation is in flight. A response stays valid and unchanged until rsp_ready is high. A memory request holds its address until accepted, and any response latency is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root_frame | input | 40 | Frame number of the root table |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry returned by memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_paddr | output | 52 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 ok, 1 non-canonical, 2 not present, 3 protection |
| rsp_level | output | 2 | Leaf level: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| rsp_perm_w | output | 1 | Merged write permission |
| rsp_perm_u | output | 1 | Merged user permission |
| rsp_perm_nx | output | 1 | Merged no-execute |

## Verification
Several properties are checked by assertions on every cycle:
- memory and result handshakes hold steady under backpressure;
- a non-canonical result never follows a memory read;
- no walk exceeds four reads;
- a successful result keeps the page offset;
- a successful result never grants an access the merged permissions deny.

Other behaviour depends on concrete table contents, so only the bench's scenarios can show it: the exact entry addresses read, the leaf chosen at each level, large-page frame masking, the ignored bits, and the merged permission values. The scenarios build tables in a model memory with variable latency and stalls, then compare every field of every response against a scoreboard.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      PTW_OK       = 2'd0,
      PTW_NONCANON = 2'd1,
      PTW_ABSENT   = 2'd2,
      PTW_PROT     = 2'd3
   } ptw_fault_e;

   typedef enum logic [1:0] {
      PTW_IDLE  = 2'd0,
      PTW_MREQ  = 2'd1,
      PTW_MWAIT = 2'd2,
      PTW_RESP  = 2'd3
   } ptw_state_e;

   localparam int ENT_PRESENT = 0;
   localparam int ENT_WRITE   = 1;
   localparam int ENT_USER    = 2;
   localparam int ENT_LARGE   = 7;

endpackage

// File: rtl/ptw_canon.sv
module ptw_canon #(
   parameter int ADDR_BITS = 64,
   parameter int VA_BITS   = 48,
   parameter bit CHECK     = 1'b1
) (
   input  logic [ADDR_BITS-VA_BITS:0] va_top,
   output logic                       ok
);
   generate
      if (!CHECK || ADDR_BITS == VA_BITS) begin : g_bypass
         logic unused_va;
         assign unused_va = ^va_top;
         assign ok = 1'b1;
      end else begin : g_check
         assign ok = (&va_top) | ~(|va_top);
      end
   endgenerate
endmodule

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
   parameter int LEVELS   = 4,
   parameter int IDX_BITS = 9,
   parameter int LVL_W    = $clog2(LEVELS)
) (
   input  logic [LEVELS*IDX_BITS-1:0] va_idx,
   input  logic [LVL_W-1:0]           lvl,
   output logic [IDX_BITS-1:0]        idx
);
   logic [IDX_BITS-1:0] slice [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_slice
      assign slice[g] = va_idx[g*IDX_BITS +: IDX_BITS];
   end

   assign idx = slice[lvl];
endmodule

// File: rtl/ptw_leaf_addr.sv
module ptw_leaf_addr #(
   parameter int PA_BITS  = 52,
   parameter int LEVELS   = 4,
   parameter int IDX_BITS = 9,
   parameter int OFF_BITS = 12,
   parameter int LVL_W    = $clog2(LEVELS),
   parameter int FRM_W    = PA_BITS - OFF_BITS,
   parameter int LOW_W    = OFF_BITS + (LEVELS-1)*IDX_BITS
) (
   input  logic [FRM_W-1:0]   frame,
   input  logic [LOW_W-1:0]   va_low,
   input  logic [LVL_W-1:0]   lvl,
   output logic [PA_BITS-1:0] paddr
);
   logic [PA_BITS-1:0] cand [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_page
      localparam int KEEP = OFF_BITS + g*IDX_BITS;
      assign cand[g] = {frame[FRM_W-1:g*IDX_BITS], va_low[KEEP-1:0]};
   end

   assign paddr = cand[lvl];
endmodule

// File: rtl/ptw_perm_merge.sv
module ptw_perm_merge (
   input  logic acc_w,
   input  logic acc_u,
   input  logic acc_nx,
   input  logic ent_w,
   input  logic ent_u,
   input  logic ent_nx,
   input  logic want_w,
   input  logic want_u,
   input  logic want_x,
   output logic m_w,
   output logic m_u,
   output logic m_nx,
   output logic deny
);
   assign m_w  = acc_w & ent_w;
   assign m_u  = acc_u & ent_u;
   assign m_nx = acc_nx | ent_nx;
   assign deny = (want_w & ~m_w) | (want_u & ~m_u) | (want_x & m_nx);
endmodule

// File: rtl/ptw4_walker.sv
module ptw4_walker
   import ptw_pkg::*;
#(
   parameter int ADDR_BITS   = 64,
   parameter int VA_BITS     = 48,
   parameter int PA_BITS     = 52,
   parameter int ENT_BITS    = 64,
   parameter int LEVELS      = 4,
   parameter int IDX_BITS    = 9,
   parameter int OFF_BITS    = 12,
   parameter int LARGE_MIN   = 1,
   parameter int LARGE_MAX   = 2,
   parameter bit CANON_CHECK = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [ADDR_BITS-1:0]         req_vaddr,
   input  logic [PA_BITS-OFF_BITS-1:0]  req_root_frame,
   input  logic                         req_write,
   input  logic                         req_user,
   input  logic                         req_fetch,
   output logic                         mem_req_valid,
   input  logic                         mem_req_ready,
   output logic [PA_BITS-1:0]           mem_req_addr,
   input  logic                         mem_rsp_valid,
   input  logic [ENT_BITS-1:0]          mem_rsp_data,
   output logic                         rsp_valid,
   input  logic                         rsp_ready,
   output logic [PA_BITS-1:0]           rsp_paddr,
   output logic [1:0]                   rsp_fault,
   output logic [$clog2(LEVELS)-1:0]    rsp_level,
   output logic                         rsp_perm_w,
   output logic                         rsp_perm_u,
   output logic                         rsp_perm_nx
);
   localparam int LVL_W   = $clog2(LEVELS);
   localparam int FRM_W   = PA_BITS - OFF_BITS;
   localparam int ENT_LOG = $clog2(ENT_BITS/8);
   localparam int LOW_W   = OFF_BITS + (LEVELS-1)*IDX_BITS;
   localparam int NX_BIT  = ENT_BITS - 1;
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS-1);
   localparam logic [LVL_W-1:0] LG_LO   = LVL_W'(LARGE_MIN);
   localparam logic [LVL_W-1:0] LG_HI   = LVL_W'(LARGE_MAX);

   // elaboration-time parameter checks
   if (OFF_BITS != IDX_BITS + ENT_LOG) begin : g_bad_off
      $error("page offset must equal index width plus entry size log");
   end
   if (VA_BITS != OFF_BITS + LEVELS*IDX_BITS) begin : g_bad_va
      $error("virtual width must be offset plus all index fields");
   end
   if (ADDR_BITS < VA_BITS || PA_BITS >= ENT_BITS) begin : g_bad_width
      $error("address widths do not fit the entry format");
   end
   if (LARGE_MIN < 1 || LARGE_MAX > LEVELS-2 || LARGE_MIN > LARGE_MAX) begin : g_bad_large
      $error("large-page levels must lie strictly inside the walk");
   end

   ptw_state_e         state_q;
   logic [LVL_W-1:0]   lvl_q;
   logic [FRM_W-1:0]   frame_q;
   logic [VA_BITS-1:0] va_q;
   logic               want_w_q, want_u_q, want_x_q;
   logic               acc_w_q, acc_u_q, acc_nx_q;
   logic [PA_BITS-1:0] paddr_q;
   ptw_fault_e         fault_q;
   logic [LVL_W-1:0]   leaf_q;
   logic               pw_q, pu_q, pnx_q;
   logic [LVL_W:0]     reads_q;

   logic               canon_ok;
   logic [IDX_BITS-1:0] idx;
   logic [PA_BITS-1:0] leaf_pa;
   logic               m_w, m_u, m_nx, deny;
   logic               ent_present, ent_large, at_leaf;
   logic               unused_ent;

   ptw_canon #(.ADDR_BITS(ADDR_BITS), .VA_BITS(VA_BITS), .CHECK(CANON_CHECK)) u_canon (
      .va_top (req_vaddr[ADDR_BITS-1:VA_BITS-1]),
      .ok     (canon_ok)
   );

   ptw_idx_sel #(.LEVELS(LEVELS), .IDX_BITS(IDX_BITS)) u_idx (
      .va_idx (va_q[VA_BITS-1:OFF_BITS]),
      .lvl    (lvl_q),
      .idx    (idx)
   );

   ptw_leaf_addr #(.PA_BITS(PA_BITS), .LEVELS(LEVELS), .IDX_BITS(IDX_BITS),
                   .OFF_BITS(OFF_BITS)) u_leaf (
      .frame  (mem_rsp_data[PA_BITS-1:OFF_BITS]),
      .va_low (va_q[LOW_W-1:0]),
      .lvl    (lvl_q),
      .paddr  (leaf_pa)
   );

   ptw_perm_merge u_perm (
      .acc_w  (acc_w_q),
      .acc_u  (acc_u_q),
      .acc_nx (acc_nx_q),
      .ent_w  (mem_rsp_data[ENT_WRITE]),
      .ent_u  (mem_rsp_data[ENT_USER]),
      .ent_nx (mem_rsp_data[NX_BIT]),
      .want_w (want_w_q),
      .want_u (want_u_q),
      .want_x (want_x_q),
      .m_w    (m_w),
      .m_u    (m_u),
      .m_nx   (m_nx),
      .deny   (deny)
   );

   assign ent_present = mem_rsp_data[ENT_PRESENT];
   assign ent_large   = mem_rsp_data[ENT_LARGE];
   assign at_leaf     = (lvl_q == '0) || (ent_large && lvl_q >= LG_LO && lvl_q <= LG_HI);
   assign unused_ent  = ^{mem_rsp_data[ENT_BITS-2:PA_BITS],
                          mem_rsp_data[OFF_BITS-1:ENT_LARGE+1],
                          mem_rsp_data[ENT_LARGE-1:ENT_USER+1]};

   assign req_ready     = (state_q == PTW_IDLE);
   assign mem_req_valid = (state_q == PTW_MREQ);
   assign rsp_valid     = (state_q == PTW_RESP);
   assign mem_req_addr  = {frame_q, idx, {ENT_LOG{1'b0}}};
   assign rsp_paddr     = paddr_q;
   assign rsp_fault     = fault_q;
   assign rsp_level     = leaf_q;
   assign rsp_perm_w    = pw_q;
   assign rsp_perm_u    = pu_q;
   assign rsp_perm_nx   = pnx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PTW_IDLE;
         lvl_q    <= '0;
         frame_q  <= '0;
         va_q     <= '0;
         want_w_q <= 1'b0;
         want_u_q <= 1'b0;
         want_x_q <= 1'b0;
         acc_w_q  <= 1'b0;
         acc_u_q  <= 1'b0;
         acc_nx_q <= 1'b0;
         paddr_q  <= '0;
         fault_q  <= PTW_OK;
         leaf_q   <= '0;
         pw_q     <= 1'b0;
         pu_q     <= 1'b0;
         pnx_q    <= 1'b0;
         reads_q  <= '0;
      end else begin
         case (state_q)
            PTW_IDLE: begin
               if (req_valid) begin
                  va_q     <= req_vaddr[VA_BITS-1:0];
                  want_w_q <= req_write;
                  want_u_q <= req_user;
                  want_x_q <= req_fetch;
                  reads_q  <= '0;
                  lvl_q    <= TOP_LVL;
                  frame_q  <= req_root_frame;
                  acc_w_q  <= 1'b1;
                  acc_u_q  <= 1'b1;
                  acc_nx_q <= 1'b0;
                  if (!canon_ok) begin
                     fault_q <= PTW_NONCANON;
                     paddr_q <= '0;
                     leaf_q  <= '0;
                     pw_q    <= 1'b0;
                     pu_q    <= 1'b0;
                     pnx_q   <= 1'b0;
                     state_q <= PTW_RESP;
                  end else begin
                     state_q <= PTW_MREQ;
                  end
               end
            end
            PTW_MREQ: begin
               if (mem_req_ready) begin
                  reads_q <= reads_q + 1'b1;
                  state_q <= PTW_MWAIT;
               end
            end
            PTW_MWAIT: begin
               if (mem_rsp_valid) begin
                  if (!ent_present) begin
                     fault_q <= PTW_ABSENT;
                     paddr_q <= '0;
                     leaf_q  <= '0;
                     pw_q    <= 1'b0;
                     pu_q    <= 1'b0;
                     pnx_q   <= 1'b0;
                     state_q <= PTW_RESP;
                  end else if (at_leaf) begin
                     fault_q <= deny ? PTW_PROT : PTW_OK;
                     paddr_q <= deny ? '0 : leaf_pa;
                     leaf_q  <= lvl_q;
                     pw_q    <= m_w;
                     pu_q    <= m_u;
                     pnx_q   <= m_nx;
                     state_q <= PTW_RESP;
                  end else begin
                     acc_w_q  <= m_w;
                     acc_u_q  <= m_u;
                     acc_nx_q <= m_nx;
                     frame_q  <= mem_rsp_data[PA_BITS-1:OFF_BITS];
                     lvl_q    <= lvl_q - 1'b1;
                     state_q  <= PTW_MREQ;
                  end
               end
            end
            PTW_RESP: begin
               if (rsp_ready) state_q <= PTW_IDLE;
            end
            default: state_q <= PTW_IDLE;
         endcase
      end
   end

   // R1
   noncanon_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == PTW_NONCANON) |-> (reads_q == '0));

   // R9
   walk_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (reads_q <= (LVL_W+1)'(LEVELS)));

   // R9
   memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R9
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

   // R6
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == PTW_OK) |-> (rsp_paddr[OFF_BITS-1:0] == va_q[OFF_BITS-1:0]));

   // R8
   perm_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == PTW_OK) |->
         ((!want_w_q || rsp_perm_w) && (!want_u_q || rsp_perm_u) && (!want_x_q || !rsp_perm_nx)));

endmodule

// File: tb/ptw4_walker_test.sv
module ptw4_walker_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready;
   logic [63:0] req_vaddr;
   logic [39:0] req_root_frame;
   logic        req_write, req_user, req_fetch;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [51:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [51:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic [1:0]  rsp_level;
   logic        rsp_perm_w, rsp_perm_u, rsp_perm_nx;

   always #4 clk = ~clk;

   ptw4_walker uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_root_frame(req_root_frame), .req_write(req_write), .req_user(req_user),
      .req_fetch(req_fetch),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_level(rsp_level), .rsp_perm_w(rsp_perm_w),
      .rsp_perm_u(rsp_perm_u), .rsp_perm_nx(rsp_perm_nx)
   );

   typedef struct {
      logic [51:0] paddr;
      logic [1:0]  fault;
      logic [1:0]  lvl;
      logic [2:0]  perm;
      int          reads;
   } exp_t;

   exp_t        expq[$];
   string       tagq[$];
   logic [63:0] mem [logic [51:0]];
   logic [51:0] addr_log[$];
   int          total = 0;
   int          bad = 0;
   int          cyc = 0;
   int          rd_total = 0;
   int          last_rd = 0;
   int          lat_cnt = 0;
   logic [63:0] rd_data_q;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // table memory with stalls and variable latency
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_req_ready <= 1'b0;
         mem_rsp_valid <= 1'b0;
         mem_rsp_data  <= '0;
         lat_cnt       <= 0;
      end else begin
         mem_req_ready <= (cyc % 4) != 1;
         mem_rsp_valid <= 1'b0;
         if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
               mem_rsp_valid <= 1'b1;
               mem_rsp_data  <= rd_data_q;
            end
         end
         if (mem_req_valid && mem_req_ready) begin
            rd_total  <= rd_total + 1;
            lat_cnt   <= 1 + (rd_total % 3);
            rd_data_q <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
            addr_log.push_back(mem_req_addr);
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      rsp_ready = (cyc % 3) != 0;
      if (rst_n && rsp_valid && rsp_ready) begin
         if (expq.size() == 0) begin
            chk("R9 unexpected response", 64'(rsp_fault), 64'hF);
         end else begin
            exp_t  e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            chk({t, " paddr"}, 64'(rsp_paddr), 64'(e.paddr));
            chk({t, " fault"}, 64'(rsp_fault), 64'(e.fault));
            chk({t, " level"}, 64'(rsp_level), 64'(e.lvl));
            chk({t, " perms"}, 64'({rsp_perm_w, rsp_perm_u, rsp_perm_nx}), 64'(e.perm));
            chk({t, " reads"}, 64'(rd_total - last_rd), 64'(e.reads));
         end
         last_rd = rd_total;
      end
   end

   task automatic send(input logic [63:0] va, input logic wr, input logic us, input logic fe,
                       input logic [51:0] ep, input logic [1:0] ef, input logic [1:0] el,
                       input logic [2:0] eperm, input int er, input string tag);
      exp_t e;
      e.paddr = ep; e.fault = ef; e.lvl = el; e.perm = eperm; e.reads = er;
      expq.push_back(e);
      tagq.push_back(tag);
      @(negedge clk);
      req_vaddr = va; req_write = wr; req_user = us; req_fetch = fe;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R9 watchdog expired act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0; req_vaddr = '0; req_root_frame = 40'h100;
      req_write = 1'b0; req_user = 1'b0; req_fetch = 1'b0;

      // tables: root at frame 0x100
      mem[52'h100008] = 64'h0000_0000_0010_1007;   // root idx1 -> 0x101
      mem[52'h100800] = 64'h8000_0000_0010_1087;   // root idx256 -> 0x101, NX, bit7
      mem[52'h101010] = 64'h0000_0000_0010_2007;   // idx2 -> 0x102
      mem[52'h101020] = 64'h0000_0000_0010_4006;   // idx4 not present
      mem[52'h101030] = 64'h0000_0000_C000_0085;   // idx6 1G leaf, no write
      mem[52'h102018] = 64'h0000_0000_0010_3007;   // idx3 -> 0x103
      mem[52'h102030] = 64'h0000_0004_0080_1083;   // idx6 2M leaf, no user, bit12 set
      mem[52'h103020] = 64'h0000_0000_1234_5E07;   // idx4 4K leaf, bits 11:9 set

      repeat (3) @(negedge clk);
      chk("R9 reset req_ready", 64'(req_ready), 64'h1);
      chk("R9 reset rsp_valid", 64'(rsp_valid), 64'h0);
      chk("R9 reset mem_req_valid", 64'(mem_req_valid), 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      send(64'h0000_0080_8060_4ABC, 0, 0, 0, 52'h1234_5ABC, 2'd0, 2'd0, 3'b110, 4, "R6 4K read");
      send(64'h0000_0080_8060_4ABC, 1, 1, 1, 52'h1234_5ABC, 2'd0, 2'd0, 3'b110, 4, "R8 4K all allowed");
      send(64'hFFFF_8000_8060_4123, 0, 0, 0, 52'h1234_5123, 2'd0, 2'd0, 3'b111, 4, "R7 R6 upper half nx merge");
      send(64'hFFFF_8000_8060_4123, 0, 0, 1, 52'h0, 2'd3, 2'd0, 3'b111, 4, "R8 fetch denied");
      send(64'h0000_0081_8060_9010, 0, 1, 0, 52'hC060_9010, 2'd0, 2'd2, 3'b010, 2, "R4 1G leaf");
      send(64'h0000_0081_8060_9010, 1, 0, 0, 52'h0, 2'd3, 2'd2, 3'b010, 2, "R8 R7 1G write denied");
      send(64'h0000_0080_80C1_ABCD, 1, 0, 0, 52'h4_0081_ABCD, 2'd0, 2'd1, 3'b100, 3, "R5 2M leaf");
      send(64'h0000_0080_80C1_ABCD, 0, 1, 0, 52'h0, 2'd3, 2'd1, 3'b100, 3, "R8 2M user denied");
      send(64'h0000_0080_8060_8055, 0, 0, 0, 52'h0, 2'd2, 2'd0, 3'b000, 4, "R3 absent at last level");
      send(64'h0000_0380_0000_0000, 0, 0, 0, 52'h0, 2'd2, 2'd0, 3'b000, 1, "R3 absent at root");
      send(64'h0000_0080_C000_0000, 0, 0, 0, 52'h0, 2'd2, 2'd0, 3'b000, 2, "R3 absent second");
      send(64'h0000_0081_0000_0000, 0, 0, 0, 52'h0, 2'd2, 2'd0, 3'b000, 2, "R3 present bit clear");
      send(64'h0001_0000_0000_0000, 0, 0, 0, 52'h0, 2'd1, 2'd0, 3'b000, 0, "R1 noncanonical low");
      send(64'h0000_8000_0000_0000, 0, 0, 0, 52'h0, 2'd1, 2'd0, 3'b000, 0, "R1 bit47 without extension");
      send(64'hFFFE_8000_8060_4123, 1, 1, 1, 52'h0, 2'd1, 2'd0, 3'b000, 0, "R1 partial extension");

      for (int i = 0; i < 2000 && expq.size() != 0; i++) @(negedge clk);
      chk("R9 all responses returned", 64'(expq.size()), 64'h0);

      if (addr_log.size() >= 4) begin
         chk("R2 read 1 address", 64'(addr_log[0]), 64'h10_0008);
         chk("R2 read 2 address", 64'(addr_log[1]), 64'h10_1010);
         chk("R2 read 3 address", 64'(addr_log[2]), 64'h10_2018);
         chk("R2 read 4 address", 64'(addr_log[3]), 64'h10_3020);
      end else begin
         chk("R2 read count", 64'(addr_log.size()), 64'h4);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule